// File: doc/BRIEF.md
# Quarter-Rate IF Downconverter With Sample Tagging

This block turns real samples of an intermediate frequency, taken below the Nyquist rate, into baseband in-phase and quadrature pairs for two receive paths, one per polarization (H and V). A 50 MHz IF sampled at 40 MHz folds down to 10 MHz, which is exactly one quarter of the sample rate. The mixing therefore reduces to a four-step pattern of pass, zero and negate, and needs no multipliers. Each of the four resulting streams then goes through a symmetric FIR low-pass filter with 16-bit coefficients and is decimated by four.

Each decimated output carries a timestamp, azimuth and elevation words and the transmit polarization code. These values are captured from the block's inputs on the clock edge that raises the output strobe. Downstream logic therefore sees every baseband sample already joined to the antenna pointing and transmit state that held when it was produced.

A small state machine sequences the work. It has four named states: PH_0, PH_1, PH_2 and PH_3. Reset enters PH_0. Each accepted sample moves the machine one step: PH_0 to PH_1, PH_1 to PH_2, PH_2 to PH_3, and PH_3 wraps back to PH_0. A cycle with no accepted sample holds the current state. The state selects the mixing sign for the sample being accepted. The step from PH_3 to PH_0 fires the decimated output.

Top module: `ddc_tagged_rx`

## Requirements
- R1: While reset is low, out_valid is 0 and every data and tag output is 0.
- R2: Count the accepted samples from reset as n = 0, 1, 2, … and let p = n mod 4. The I value fed to the filter is +x for p=0, 0 for p=1, −x for p=2 and 0 for p=3. The Q value is 0 for p=0, −x for p=1, 0 for p=2 and +x for p=3.
- R3: Negating the most negative sample (−32768) gives +32767.
- R4: The filter keeps an 8-entry line of mixed samples, with d0 the newest. Its output is floor(S / 2^15), where S = 4096·(d0+d7) + 8192·(d1+d6) + 12288·(d2+d5) + 16384·(d3+d4).
- R5: out_valid is high for exactly one cycle, two clock edges after the edge that accepts each sample with p=3. At all other times it is low.
- R6: A cycle with adc_valid low leaves the delay lines and the mixing phase unchanged, so gaps in the sample stream do not change the results.
- R7: Each output saturates to the signed 16-bit range [−32768, 32767].
- R8: out_time, out_az, out_el and out_pol take the values of time_in, az_in, el_in and pol_in at the edge where out_valid rises. They keep those values until the next output.
- R9: The H and V paths are processed the same way and do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_valid | input | 1 | Sample strobe for both channels |
| adc_h | input | 16 | Signed IF sample, H channel |
| adc_v | input | 16 | Signed IF sample, V channel |
| time_in | input | 32 | Running time count |
| az_in | input | 16 | Antenna azimuth word |
| el_in | input | 16 | Antenna elevation word |
| pol_in | input | 2 | Transmit polarization code |
| out_valid | output | 1 | One-cycle strobe per decimated sample |
| out_h_i | output | 16 | H channel in-phase output |
| out_h_q | output | 16 | H channel quadrature output |
| out_v_i | output | 16 | V channel in-phase output |
| out_v_q | output | 16 | V channel quadrature output |
| out_time | output | 32 | Captured time tag |
| out_az | output | 16 | Captured azimuth tag |
| out_el | output | 16 | Captured elevation tag |
| out_pol | output | 2 | Captured polarization tag |

## Verification
The assertions check the following on every cycle:
- the output strobe appears exactly two edges after every fourth accepted sample, and never in any other cycle;
- the strobe never lasts longer than one cycle;
- the tags equal the inputs from the strobe edge and stay stable between strobes;
- all outputs stay at zero during reset.

Only the bench scenarios can show the arithmetic. This covers the per-phase mixing signs, the filter sums, the negation and output saturation at full scale, the insensitivity to gaps in the sample stream, and the independence of the H and V paths. These are checked against a model built from the requirements.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

    // Position within the four-sample quarter-rate mixing cycle.
    typedef enum logic [1:0] {
        PH_0 = 2'd0,
        PH_1 = 2'd1,
        PH_2 = 2'd2,
        PH_3 = 2'd3
    } ph_e;

    // Operation the mixer applies to one sample.
    typedef enum logic [1:0] {
        MX_ZERO = 2'd0,
        MX_PASS = 2'd1,
        MX_NEG  = 2'd2
    } mix_e;

    localparam int NCH = 2;   // H and V receive paths

endpackage

// File: rtl/ddc_phase_seq.sv
module ddc_phase_seq
    import ddc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic smp_valid,
    output ph_e  phase,
    output mix_e i_mode,
    output mix_e q_mode,
    output logic dec_fire
);

    ph_e state, state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_0;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic: advance only on accepted samples
    always_comb begin
        state_nx = state;
        if (smp_valid) begin
            unique case (state)
                PH_0: state_nx = PH_1;
                PH_1: state_nx = PH_2;
                PH_2: state_nx = PH_3;
                PH_3: state_nx = PH_0;
            endcase
        end
    end

    // Output decode
    always_comb begin
        i_mode = MX_ZERO;
        q_mode = MX_ZERO;
        unique case (state)
            PH_0: begin i_mode = MX_PASS; q_mode = MX_ZERO; end
            PH_1: begin i_mode = MX_ZERO; q_mode = MX_NEG;  end
            PH_2: begin i_mode = MX_NEG;  q_mode = MX_ZERO; end
            PH_3: begin i_mode = MX_ZERO; q_mode = MX_PASS; end
        endcase
        dec_fire = smp_valid && (state == PH_3);
    end

    assign phase = state;

endmodule

// File: rtl/ddc_qmix.sv
module ddc_qmix
    import ddc_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic signed [DW-1:0] x,
    input  mix_e                 mode,
    output logic signed [DW-1:0] y
);

    localparam logic signed [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};
    localparam logic signed [DW-1:0] MOST_POS = {1'b0, {(DW-1){1'b1}}};

    logic signed [DW-1:0] x_neg;

    // Negation clipped so the most negative code does not wrap.
    assign x_neg = (x == MOST_NEG) ? MOST_POS : -x;

    always_comb begin
        unique case (mode)
            MX_PASS: y = x;
            MX_NEG:  y = x_neg;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/ddc_fir_dec.sv
module ddc_fir_dec #(
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int TAPS  = 8,
    parameter int SHIFT = 15,
    parameter logic [(TAPS/2)*CW-1:0] HALF_COEFS =
        {16'sd16384, 16'sd12288, 16'sd8192, 16'sd4096}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic signed [DW-1:0] din,
    output logic signed [DW-1:0] dout
);

    localparam int HALF = TAPS / 2;
    localparam int PW   = DW + 1;                      // pre-adder width
    localparam int MW   = PW + CW;                     // product width
    localparam int AW   = MW + $clog2(HALF) + 1;       // accumulator width

    logic signed [DW-1:0] dl    [TAPS];
    logic signed [MW-1:0] prods [HALF];
    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] shifted;
    logic [AW-DW:0]       hi_bits;
    logic                 ovf;

    // Delay line, advanced only on accepted samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TAPS; i++) dl[i] <= '0;
        end else if (shift_en) begin
            dl[0] <= din;
            for (int i = 1; i < TAPS; i++) dl[i] <= dl[i-1];
        end
    end

    // Symmetric pairs: one multiply per pair of taps
    for (genvar k = 0; k < HALF; k++) begin : g_pair
        logic signed [CW-1:0] cf;
        logic signed [PW-1:0] pre;
        assign cf  = HALF_COEFS[k*CW +: CW];
        assign pre = {dl[k][DW-1], dl[k]} + {dl[TAPS-1-k][DW-1], dl[TAPS-1-k]};
        assign prods[k] = pre * cf;
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < HALF; k++) begin
            acc = acc + {{(AW-MW){prods[k][MW-1]}}, prods[k]};
        end
    end

    assign shifted = acc >>> SHIFT;
    assign hi_bits = shifted[AW-1:DW-1];
    assign ovf     = !((&hi_bits) || (~|hi_bits));

    always_comb begin
        if (ovf) begin
            dout = shifted[AW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
        end else begin
            dout = shifted[DW-1:0];
        end
    end

endmodule

// File: rtl/ddc_tagged_rx.sv
module ddc_tagged_rx
    import ddc_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int TAPS  = 8,
    parameter int SHIFT = 15,
    parameter logic [(TAPS/2)*CW-1:0] HALF_COEFS =
        {16'sd16384, 16'sd12288, 16'sd8192, 16'sd4096},
    parameter int TW    = 32,
    parameter int ANGW  = 16,
    parameter int POLW  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   adc_valid,
    input  logic signed [DW-1:0]   adc_h,
    input  logic signed [DW-1:0]   adc_v,
    input  logic [TW-1:0]          time_in,
    input  logic [ANGW-1:0]        az_in,
    input  logic [ANGW-1:0]        el_in,
    input  logic [POLW-1:0]        pol_in,
    output logic                   out_valid,
    output logic signed [DW-1:0]   out_h_i,
    output logic signed [DW-1:0]   out_h_q,
    output logic signed [DW-1:0]   out_v_i,
    output logic signed [DW-1:0]   out_v_q,
    output logic [TW-1:0]          out_time,
    output logic [ANGW-1:0]        out_az,
    output logic [ANGW-1:0]        out_el,
    output logic [POLW-1:0]        out_pol
);

    ph_e  phase;
    mix_e i_mode, q_mode;
    logic dec_fire;
    logic calc_q;

    logic signed [DW-1:0] adc    [NCH];
    logic signed [DW-1:0] mix_i  [NCH];
    logic signed [DW-1:0] mix_q  [NCH];
    logic signed [DW-1:0] filt_i [NCH];
    logic signed [DW-1:0] filt_q [NCH];

    assign adc[0] = adc_h;
    assign adc[1] = adc_v;

    ddc_phase_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (adc_valid),
        .phase     (phase),
        .i_mode    (i_mode),
        .q_mode    (q_mode),
        .dec_fire  (dec_fire)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        ddc_qmix #(.DW(DW)) u_mix_i (.x(adc[ch]), .mode(i_mode), .y(mix_i[ch]));
        ddc_qmix #(.DW(DW)) u_mix_q (.x(adc[ch]), .mode(q_mode), .y(mix_q[ch]));

        ddc_fir_dec #(
            .DW(DW), .CW(CW), .TAPS(TAPS), .SHIFT(SHIFT), .HALF_COEFS(HALF_COEFS)
        ) u_fir_i (
            .clk(clk), .rst_n(rst_n), .shift_en(adc_valid),
            .din(mix_i[ch]), .dout(filt_i[ch])
        );

        ddc_fir_dec #(
            .DW(DW), .CW(CW), .TAPS(TAPS), .SHIFT(SHIFT), .HALF_COEFS(HALF_COEFS)
        ) u_fir_q (
            .clk(clk), .rst_n(rst_n), .shift_en(adc_valid),
            .din(mix_q[ch]), .dout(filt_q[ch])
        );
    end

    // Decimation strobe: one cycle after the fourth sample is in the line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            calc_q <= 1'b0;
        end else begin
            calc_q <= dec_fire;
        end
    end

    // Output and tag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_h_i   <= '0;
            out_h_q   <= '0;
            out_v_i   <= '0;
            out_v_q   <= '0;
            out_time  <= '0;
            out_az    <= '0;
            out_el    <= '0;
            out_pol   <= '0;
        end else begin
            out_valid <= calc_q;
            if (calc_q) begin
                out_h_i  <= filt_i[0];
                out_h_q  <= filt_q[0];
                out_v_i  <= filt_i[1];
                out_v_q  <= filt_q[1];
                out_time <= time_in;
                out_az   <= az_in;
                out_el   <= el_in;
                out_pol  <= pol_in;
            end
        end
    end

endmodule

// File: rtl/ddc_tagged_rx_chk.sv
module ddc_tagged_rx_chk #(
    parameter int DW   = 16,
    parameter int TW   = 32,
    parameter int ANGW = 16,
    parameter int POLW = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 adc_valid,
    input logic [TW-1:0]        time_in,
    input logic [ANGW-1:0]      az_in,
    input logic [ANGW-1:0]      el_in,
    input logic [POLW-1:0]      pol_in,
    input logic                 out_valid,
    input logic [DW-1:0]        out_h_i,
    input logic [DW-1:0]        out_h_q,
    input logic [DW-1:0]        out_v_i,
    input logic [DW-1:0]        out_v_q,
    input logic [TW-1:0]        out_time,
    input logic [ANGW-1:0]      out_az,
    input logic [ANGW-1:0]      out_el,
    input logic [POLW-1:0]      out_pol
);

    // Independent count of accepted samples modulo four
    logic [1:0] smp_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         smp_cnt <= '0;
        else if (adc_valid) smp_cnt <= smp_cnt + 2'd1;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (!out_valid && out_h_i == '0 && out_h_q == '0 &&
                                           out_v_i == '0 && out_v_q == '0 && out_time == '0 &&
                                           out_az == '0 && out_el == '0 && out_pol == '0);
        end
    end

    assert_fire_after_fourth_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_valid && smp_cnt == 2'd3) |-> ##2 out_valid);

    assert_no_stray_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(adc_valid && smp_cnt == 2'd3, 2));

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_tag_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_time == $past(time_in) && out_az == $past(az_in) &&
                       out_el == $past(el_in) && out_pol == $past(pol_in)));

    assert_tag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_time) && $stable(out_az) &&
                        $stable(out_el) && $stable(out_pol)));

endmodule

bind ddc_tagged_rx ddc_tagged_rx_chk #(
    .DW(DW), .TW(TW), .ANGW(ANGW), .POLW(POLW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .adc_valid(adc_valid),
    .time_in(time_in), .az_in(az_in), .el_in(el_in), .pol_in(pol_in),
    .out_valid(out_valid), .out_h_i(out_h_i), .out_h_q(out_h_q),
    .out_v_i(out_v_i), .out_v_q(out_v_q), .out_time(out_time),
    .out_az(out_az), .out_el(out_el), .out_pol(out_pol)
);

// File: tb/ddc_tagged_rx_bench.sv
module ddc_tagged_rx_bench;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic adc_valid = 1'b0;
    logic signed [15:0] adc_h = '0, adc_v = '0;
    logic [31:0] time_in = '0;
    logic [15:0] az_in = '0, el_in = '0;
    logic [1:0]  pol_in = '0;
    logic out_valid;
    logic signed [15:0] out_h_i, out_h_q, out_v_i, out_v_q;
    logic [31:0] out_time;
    logic [15:0] out_az, out_el;
    logic [1:0]  out_pol;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddc_tagged_rx u_ddc_tagged_rx (
        .clk(clk), .rst_n(rst_n), .adc_valid(adc_valid),
        .adc_h(adc_h), .adc_v(adc_v), .time_in(time_in),
        .az_in(az_in), .el_in(el_in), .pol_in(pol_in),
        .out_valid(out_valid), .out_h_i(out_h_i), .out_h_q(out_h_q),
        .out_v_i(out_v_i), .out_v_q(out_v_q), .out_time(out_time),
        .out_az(out_az), .out_el(out_el), .out_pol(out_pol)
    );

    int n_chk = 0, n_fail = 0;
    string cur_req = "R2";

    // Model state
    longint d_hi[8], d_hq[8], d_vi[8], d_vq[8];
    longint n_acc;
    int     due;
    longint e_hi, e_hq, e_vi, e_vq;
    longint last_time, last_az, last_el, last_pol;
    bit     seen_out;
    longint coef[4] = '{4096, 8192, 12288, 16384};

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic longint neg16(input longint x);
        return (x == -32768) ? 32767 : -x;
    endfunction

    function automatic longint sat16(input longint x);
        if (x > 32767)  return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    function automatic longint fir(input longint d[8]);
        longint s = 0;
        for (int k = 0; k < 4; k++) s += coef[k] * (d[k] + d[7-k]);
        return sat16(s >>> 15);
    endfunction

    task automatic shift_in(inout longint d[8], input longint x);
        for (int i = 7; i > 0; i--) d[i] = d[i-1];
        d[0] = x;
    endtask

    task automatic model_push(input longint h, input longint v);
        int p = int'(n_acc % 4);
        longint hi, hq, vi, vq;
        hi = (p == 0) ? h : (p == 2) ? neg16(h) : 0;
        hq = (p == 3) ? h : (p == 1) ? neg16(h) : 0;
        vi = (p == 0) ? v : (p == 2) ? neg16(v) : 0;
        vq = (p == 3) ? v : (p == 1) ? neg16(v) : 0;
        shift_in(d_hi, hi); shift_in(d_hq, hq);
        shift_in(d_vi, vi); shift_in(d_vq, vq);
        n_acc++;
        if (p == 3) begin
            e_hi = fir(d_hi); e_hq = fir(d_hq);
            e_vi = fir(d_vi); e_vq = fir(d_vq);
            due = 2;
        end
    endtask

    task automatic check_outputs();
        if (due > 0) due--;
        if (due == 0) begin
            chk("R5 valid", longint'(out_valid), 1);
            chk({cur_req, " h_i"}, longint'(out_h_i), e_hi);
            chk({cur_req, " h_q"}, longint'(out_h_q), e_hq);
            chk({cur_req, " v_i"}, longint'(out_v_i), e_vi);
            chk({cur_req, " v_q"}, longint'(out_v_q), e_vq);
            chk("R8 time", longint'(out_time), longint'(time_in));
            chk("R8 az",   longint'(out_az),   longint'(az_in));
            chk("R8 el",   longint'(out_el),   longint'(el_in));
            chk("R8 pol",  longint'(out_pol),  longint'(pol_in));
            last_time = time_in; last_az = az_in; last_el = el_in; last_pol = pol_in;
            seen_out = 1'b1;
            due = -1;
        end else begin
            chk("R5 idle", longint'(out_valid), 0);
            if (seen_out) begin
                chk("R8 hold time", longint'(out_time), last_time);
                chk("R8 hold az",   longint'(out_az),   last_az);
                chk("R8 hold pol",  longint'(out_pol),  last_pol);
            end
        end
    endtask

    task automatic step(input bit v, input longint h, input longint vv);
        @(negedge clk);
        check_outputs();
        adc_valid = v;
        adc_h     = 16'(h);
        adc_v     = 16'(vv);
        time_in   = time_in + 1;
        az_in     = az_in + 16'd37;
        el_in     = el_in + 16'd11;
        pol_in    = pol_in + 2'd1;
        if (v) model_push(h, vv);
    endtask

    task automatic flush();
        for (int i = 0; i < 6; i++) step(1'b0, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        adc_valid = 1'b0;
        for (int i = 0; i < 8; i++) begin
            d_hi[i] = 0; d_hq[i] = 0; d_vi[i] = 0; d_vq[i] = 0;
        end
        n_acc = 0; due = -1; seen_out = 1'b0;
        @(negedge clk);
        // R1: everything quiet while reset is held
        chk("R1 valid", longint'(out_valid), 0);
        chk("R1 h_i",   longint'(out_h_i), 0);
        chk("R1 v_q",   longint'(out_v_q), 0);
        chk("R1 time",  longint'(out_time), 0);
        chk("R1 pol",   longint'(out_pol), 0);
        rst_n = 1'b1;
    endtask

    // R2/R4: cosine and sine tones at fs/4, plus a broadband pattern
    task automatic t_tone();
        do_reset();
        cur_req = "R2/R4 tone";
        for (int i = 0; i < 16; i++) begin
            longint c = (i % 4 == 0) ? 12000 : (i % 4 == 2) ? -12000 : 0;
            longint s = (i % 4 == 1) ? 9000 : (i % 4 == 3) ? -9000 : 0;
            step(1'b1, c, s);
        end
        for (int i = 0; i < 20; i++) step(1'b1, (i * 1237) % 20000 - 10000, 5000 - i * 400);
        flush();
    endtask

    // R6: idle cycles between samples must not disturb the result
    task automatic t_gaps();
        do_reset();
        cur_req = "R6 gaps";
        for (int i = 0; i < 30; i++) begin
            step(1'b1, 3000 + i * 700, -2000 + i * 313);
            if (i % 3 == 0) step(1'b0, 31111, -31111);
            if (i % 5 == 0) begin
                step(1'b0, -7777, 7777);
                step(1'b0, 123, 456);
            end
        end
        flush();
    endtask

    // R3/R7: full-scale codes, negation clip and output saturation
    task automatic t_sat();
        do_reset();
        cur_req = "R3 negclip";
        for (int i = 0; i < 12; i++) step(1'b1, (i % 4 == 2) ? -32768 : 0, (i % 4 == 1) ? -32768 : 0);
        flush();
        cur_req = "R7 sat";
        for (int i = 0; i < 16; i++) begin
            longint c = (i % 4 == 0) ? 32767 : (i % 4 == 2) ? -32767 : 0;
            longint n = (i % 4 == 0) ? -32768 : (i % 4 == 2) ? 32767 : 0;
            step(1'b1, c, n);
        end
        flush();
    endtask

    // R9: one path driven, the other silent, then swapped
    task automatic t_hv();
        do_reset();
        cur_req = "R9 H only";
        for (int i = 0; i < 12; i++) step(1'b1, 8000 - i * 900, 0);
        flush();
        cur_req = "R9 V only";
        for (int i = 0; i < 12; i++) step(1'b1, 0, -6000 + i * 1100);
        flush();
    endtask

    // R8: tags checked at every strobe and held in between
    task automatic t_tags();
        do_reset();
        cur_req = "R8 data";
        for (int i = 0; i < 24; i++) begin
            step(1'b1, i * 100, -i * 50);
            if (i % 2 == 1) step(1'b0, 0, 0);
        end
        flush();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual hung expected done");
        finish_run();
    end

    initial begin
        t_tone();
        t_gaps();
        t_sat();
        t_hv();
        t_tags();
        finish_run();
    end

endmodule